// File: doc/BRIEF.md
# Protection Entry Configuration Register File

This block holds the configuration byte and the address register for each of a fixed number of memory protection entries, and serves the machine-mode CSR writes and reads that reach them. Configuration bytes are packed several to a CSR: each config CSR is XLEN bits wide and carries XLEN/8 entry bytes. Address registers are one CSR per entry. The raw config bytes and address registers of all entries are driven out flat, so the range decoder and the permission checker downstream can read them.

Writes obey lock rules. An entry whose lock bit is set, or whose next higher entry is locked in top-of-range mode, no longer accepts writes to its config byte or its address register. A write that is dropped, in whole or in part, raises a one-cycle error flag. Reads are combinational on the request index and cost no extra cycle. Writes take effect at the clock edge that samples them.

Top module: `pmpcf_regfile`

## Requirements
- R1: After reset every config byte, every address register and `wr_err` read as zero.
- R2: Byte i (bits 8i+7..8i) of config CSR k belongs to entry k*(XLEN/8)+i. A config write stores each byte into its entry, the lowest byte into the lowest entry.
- R3: A config read returns the entry bytes of that CSR concatenated in index order. Any byte whose entry index is N_ENTRIES or more reads as zero. An address read at index N_ENTRIES or more returns zero.
- R4: With XLEN = 64, a write to an odd-numbered config CSR changes no entry and raises `wr_err`.
- R5: The lock bit is bit 7 of the config byte. While it is set, writes to that entry's config byte and to its address register are ignored, so the bit stays set until reset.
- R6: Entry j is also locked when entry j+1 has bit 7 set and its match field, bits 4:3, equals 2'b01 (top-of-range). The highest entry takes no lock from any neighbour.
- R7: A write to an address register at index N_ENTRIES or more, or to a config CSR none of whose bytes maps to an existing entry, changes nothing and raises `wr_err`.
- R8: Within one config write, the lock state from before the write masks each byte on its own. Bytes of unlocked entries are stored, bytes of locked entries are dropped, and `wr_err` is raised if any byte was dropped.
- R9: `wr_err` is high for exactly the one cycle after a write that had any part ignored. It is low after accepted writes and after idle cycles.
- R10: `cfg_flat[8j+7:8j]` and `addr_flat[XLEN*j+XLEN-1:XLEN*j]` show entry j. They change only in the cycle after an accepted write to that entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | CSR access present this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_is_cfg | input | 1 | 1 = config CSR, 0 = address CSR |
| req_idx | input | IDX_W | CSR index within its group |
| req_wdata | input | XLEN | Write data |
| rd_data | output | XLEN | Read data for req_idx / req_is_cfg (combinational) |
| wr_err | output | 1 | One-cycle flag: last write was partly or fully ignored |
| cfg_flat | output | 8*N_ENTRIES | All config bytes, entry j at bits 8j+7..8j |
| addr_flat | output | XLEN*N_ENTRIES | All address registers, entry j at slice j |

## Verification
A wrong lock evaluation shows up on the first write after the bad state. A write that should have been dropped appears on `cfg_flat` or `addr_flat` one cycle later, and a missing or spurious `wr_err` pulse appears in that same cycle. A wrong byte scatter puts a value on the wrong entry's slice of `cfg_flat` in the cycle after the write. A wrong gather is visible at once on `rd_data`, because reads are combinational. Checks made at the byte level, mixing locked and unlocked entries in one packed write, separate a per-byte mask from a per-CSR mask.

// File: rtl/pmpcf_pkg.sv
package pmpcf_pkg;
    typedef logic [7:0] cfg_byte_t;

    localparam int LOCK_POS  = 7;
    localparam int MODE_LO   = 3;
    localparam logic [1:0] MODE_TOR = 2'b01;

    // An entry whose config says "locked and top-of-range" also freezes the entry below
    function automatic logic locks_below(input cfg_byte_t c);
        return c[LOCK_POS] && (c[MODE_LO+1:MODE_LO] == MODE_TOR);
    endfunction
endpackage

// File: rtl/pmpcf_lock.sv
module pmpcf_lock #(
    parameter int N_ENTRIES = 6
) (
    input  logic [8*N_ENTRIES-1:0] cfg_flat,
    output logic [N_ENTRIES-1:0]   locked
);
    import pmpcf_pkg::*;

    for (genvar j = 0; j < N_ENTRIES; j++) begin : g_ent
        if (j == N_ENTRIES - 1) begin : g_top
            assign locked[j] = cfg_flat[8*j+LOCK_POS];
        end else begin : g_mid
            assign locked[j] = cfg_flat[8*j+LOCK_POS] |
                               locks_below(cfg_flat[8*(j+1) +: 8]);
        end
    end
endmodule

// File: rtl/pmpcf_wdec.sv
module pmpcf_wdec #(
    parameter int XLEN      = 32,
    parameter int N_ENTRIES = 6,
    parameter int IDX_W     = 6
) (
    input  logic                 req_valid,
    input  logic                 req_write,
    input  logic                 req_is_cfg,
    input  logic [IDX_W-1:0]     req_idx,
    input  logic [N_ENTRIES-1:0] locked,
    output logic [N_ENTRIES-1:0] cfg_we,
    output logic [N_ENTRIES-1:0] addr_we,
    output logic                 err
);
    localparam int BYTES = XLEN / 8;

    logic wr;
    logic odd_reject;
    logic [N_ENTRIES-1:0] cfg_hit;
    logic [N_ENTRIES-1:0] addr_hit;

    assign wr = req_valid && req_write;

    if (XLEN == 64) begin : g_rv64
        assign odd_reject = req_idx[0];
    end else begin : g_rv32
        assign odd_reject = 1'b0;
    end

    for (genvar j = 0; j < N_ENTRIES; j++) begin : g_ent
        localparam int K = j / BYTES;
        assign cfg_hit[j]  = wr && req_is_cfg && !odd_reject &&
                             (req_idx == IDX_W'(K));
        assign addr_hit[j] = wr && !req_is_cfg && (req_idx == IDX_W'(j));
        assign cfg_we[j]   = cfg_hit[j]  && !locked[j];
        assign addr_we[j]  = addr_hit[j] && !locked[j];
    end

    always_comb begin
        err = 1'b0;
        if (wr) begin
            if (req_is_cfg) begin
                err = odd_reject || (cfg_hit == '0) || ((cfg_hit & locked) != '0);
            end else begin
                err = (addr_hit == '0) || ((addr_hit & locked) != '0);
            end
        end
    end
endmodule

// File: rtl/pmpcf_rdmux.sv
module pmpcf_rdmux #(
    parameter int XLEN      = 32,
    parameter int N_ENTRIES = 6,
    parameter int IDX_W     = 6
) (
    input  logic                      req_is_cfg,
    input  logic [IDX_W-1:0]          req_idx,
    input  logic [8*N_ENTRIES-1:0]    cfg_flat,
    input  logic [XLEN*N_ENTRIES-1:0] addr_flat,
    output logic [XLEN-1:0]           rd_data
);
    localparam int BYTES = XLEN / 8;

    always_comb begin
        rd_data = '0;
        for (int j = 0; j < N_ENTRIES; j++) begin
            if (req_is_cfg) begin
                if (req_idx == IDX_W'(j / BYTES)) begin
                    rd_data[8*(j % BYTES) +: 8] = cfg_flat[8*j +: 8];
                end
            end else if (req_idx == IDX_W'(j)) begin
                rd_data = addr_flat[XLEN*j +: XLEN];
            end
        end
    end
endmodule

// File: rtl/pmpcf_regfile.sv
module pmpcf_regfile #(
    parameter int XLEN      = 32,
    parameter int N_ENTRIES = 6,
    parameter int IDX_W     = 6
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      req_valid,
    input  logic                      req_write,
    input  logic                      req_is_cfg,
    input  logic [IDX_W-1:0]          req_idx,
    input  logic [XLEN-1:0]           req_wdata,
    output logic [XLEN-1:0]           rd_data,
    output logic                      wr_err,
    output logic [8*N_ENTRIES-1:0]    cfg_flat,
    output logic [XLEN*N_ENTRIES-1:0] addr_flat
);
    localparam int BYTES = XLEN / 8;

    logic [N_ENTRIES-1:0] locked;
    logic [N_ENTRIES-1:0] cfg_we;
    logic [N_ENTRIES-1:0] addr_we;
    logic                 err_now;

    pmpcf_lock #(.N_ENTRIES(N_ENTRIES)) u_lock (
        .cfg_flat (cfg_flat),
        .locked   (locked)
    );

    pmpcf_wdec #(.XLEN(XLEN), .N_ENTRIES(N_ENTRIES), .IDX_W(IDX_W)) u_wdec (
        .req_valid  (req_valid),
        .req_write  (req_write),
        .req_is_cfg (req_is_cfg),
        .req_idx    (req_idx),
        .locked     (locked),
        .cfg_we     (cfg_we),
        .addr_we    (addr_we),
        .err        (err_now)
    );

    pmpcf_rdmux #(.XLEN(XLEN), .N_ENTRIES(N_ENTRIES), .IDX_W(IDX_W)) u_rdmux (
        .req_is_cfg (req_is_cfg),
        .req_idx    (req_idx),
        .cfg_flat   (cfg_flat),
        .addr_flat  (addr_flat),
        .rd_data    (rd_data)
    );

    for (genvar j = 0; j < N_ENTRIES; j++) begin : g_reg
        localparam int B = j % BYTES;
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                cfg_flat[8*j +: 8]        <= '0;
                addr_flat[XLEN*j +: XLEN] <= '0;
            end else begin
                if (cfg_we[j]) begin
                    cfg_flat[8*j +: 8] <= req_wdata[8*B +: 8];
                end
                if (addr_we[j]) begin
                    addr_flat[XLEN*j +: XLEN] <= req_wdata;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_err <= 1'b0;
        end else begin
            wr_err <= err_now;
        end
    end
endmodule

// File: rtl/pmpcf_chk.sv
module pmpcf_chk #(
    parameter int XLEN      = 32,
    parameter int N_ENTRIES = 6,
    parameter int IDX_W     = 6
) (
    input logic                      clk,
    input logic                      rst_n,
    input logic                      req_valid,
    input logic                      req_write,
    input logic                      req_is_cfg,
    input logic [IDX_W-1:0]          req_idx,
    input logic                      wr_err,
    input logic [8*N_ENTRIES-1:0]    cfg_flat,
    input logic [XLEN*N_ENTRIES-1:0] addr_flat
);
    AST_IDLE_NO_CHANGE: assert property (@(posedge clk) disable iff (!rst_n)
        !(req_valid && req_write) |=> ($stable(cfg_flat) && $stable(addr_flat) && !wr_err)); // R10

    AST_ERR_NEEDS_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        wr_err |-> $past(req_valid && req_write)); // R9

    AST_ADDR_OOR_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_write && !req_is_cfg && (int'(req_idx) >= N_ENTRIES))
        |=> (wr_err && $stable(addr_flat) && $stable(cfg_flat))); // R7

    if (XLEN == 64) begin : g_odd
        AST_ODD_CFG_REJECT: assert property (@(posedge clk) disable iff (!rst_n)
            (req_valid && req_write && req_is_cfg && req_idx[0])
            |=> (wr_err && $stable(cfg_flat))); // R4
    end

    for (genvar j = 0; j < N_ENTRIES; j++) begin : g_ent
        AST_LOCK_FREEZES_CFG: assert property (@(posedge clk) disable iff (!rst_n)
            cfg_flat[8*j+7] |=> $stable(cfg_flat[8*j +: 8])); // R5
        AST_LOCK_FREEZES_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
            cfg_flat[8*j+7] |=> $stable(addr_flat[XLEN*j +: XLEN])); // R5
        if (j < N_ENTRIES - 1) begin : g_tor
            AST_TOR_FREEZES_BELOW: assert property (@(posedge clk) disable iff (!rst_n)
                (cfg_flat[8*(j+1)+7] && (cfg_flat[8*(j+1)+3 +: 2] == 2'b01))
                |=> ($stable(cfg_flat[8*j +: 8]) && $stable(addr_flat[XLEN*j +: XLEN]))); // R6
        end
    end
endmodule

bind pmpcf_regfile pmpcf_chk #(.XLEN(XLEN), .N_ENTRIES(N_ENTRIES), .IDX_W(IDX_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .req_write  (req_write),
    .req_is_cfg (req_is_cfg),
    .req_idx    (req_idx),
    .wr_err     (wr_err),
    .cfg_flat   (cfg_flat),
    .addr_flat  (addr_flat)
);

// File: tb/pmpcf_regfile_tb.sv
module pmpcf_regfile_tb;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #5 clk = ~clk;

    logic        v32 = 1'b0, v64 = 1'b0;
    logic        wr = 1'b0, is_cfg = 1'b0;
    logic [5:0]  idx = '0;
    logic [63:0] wd = '0;

    logic [31:0]  rd32;
    logic         err32;
    logic [47:0]  cfg32;
    logic [191:0] addr32;
    logic [63:0]  rd64;
    logic         err64;
    logic [63:0]  cfg64;
    logic [511:0] addr64;

    pmpcf_regfile #(.XLEN(32), .N_ENTRIES(6), .IDX_W(6)) u_dut (
        .clk(clk), .rst_n(rst_n), .req_valid(v32), .req_write(wr), .req_is_cfg(is_cfg),
        .req_idx(idx), .req_wdata(wd[31:0]), .rd_data(rd32), .wr_err(err32),
        .cfg_flat(cfg32), .addr_flat(addr32)
    );

    pmpcf_regfile #(.XLEN(64), .N_ENTRIES(8), .IDX_W(6)) u_dut64 (
        .clk(clk), .rst_n(rst_n), .req_valid(v64), .req_write(wr), .req_is_cfg(is_cfg),
        .req_idx(idx), .req_wdata(wd), .rd_data(rd64), .wr_err(err64),
        .cfg_flat(cfg64), .addr_flat(addr64)
    );

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    task automatic chk(input string tag, input logic [511:0] got, input logic [511:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s got=%0h exp=%0h", tag, got, exp);
        end
    endtask

    // Write; returns after the edge, when wr_err for this write is visible
    task automatic do_wr(input bit sel64, input bit cfg, input int i, input logic [63:0] d);
        @(negedge clk);
        wr = 1'b1; is_cfg = cfg; idx = 6'(i); wd = d;
        v32 = !sel64; v64 = sel64;
        @(negedge clk);
        v32 = 1'b0; v64 = 1'b0; wr = 1'b0;
    endtask

    task automatic do_rd(input bit cfg, input int i);
        @(negedge clk);
        is_cfg = cfg; idx = 6'(i);
        #1;
    endtask

    task automatic t_reset();
        chk("R1 cfg32", cfg32, 0);
        chk("R1 addr32", addr32, 0);
        chk("R1 err32", err32, 0);
        chk("R1 cfg64", cfg64, 0);
        chk("R1 addr64", addr64, 0);
    endtask

    task automatic t_pack();
        do_wr(0, 1, 0, 64'h0D0C0B0A);
        chk("R2 entry0", cfg32[7:0], 8'h0A);
        chk("R2 entry3", cfg32[31:24], 8'h0D);
        chk("R10 err clean", err32, 0);
        do_wr(0, 1, 1, 64'h44332221);
        chk("R2 entry4", cfg32[39:32], 8'h21);
        chk("R2 entry5", cfg32[47:40], 8'h22);
        do_rd(1, 1);
        chk("R3 cfg1 missing bytes zero", rd32, 32'h00002221);
        do_rd(1, 0);
        chk("R3 cfg0 gather", rd32, 32'h0D0C0B0A);
    endtask

    task automatic t_range();
        do_wr(0, 0, 3, 64'h12345678);
        chk("R10 addr3 slice", addr32[127:96], 32'h12345678);
        do_rd(0, 3);
        chk("R3 addr3 read", rd32, 32'h12345678);
        do_wr(0, 0, 6, 64'hFFFF);
        chk("R7 addr oor err", err32, 1);
        chk("R7 addr oor no change", addr32, {64'h0, 32'h12345678, 96'h0});
        @(negedge clk);
        chk("R9 err one cycle", err32, 0);
        do_rd(0, 6);
        chk("R3 addr oor reads zero", rd32, 0);
        do_wr(0, 1, 2, 64'h01010101);
        chk("R7 cfg csr without entries err", err32, 1);
        chk("R7 cfg unchanged", cfg32, 48'h22210D0C0B0A);
    endtask

    task automatic t_lock();
        do_wr(0, 0, 2, 64'hAAAA0000);
        do_wr(0, 1, 0, 64'h0D800B0A);
        chk("R5 lock set no err", err32, 0);
        do_wr(0, 0, 2, 64'h5555);
        chk("R5 locked addr err", err32, 1);
        do_rd(0, 2);
        chk("R5 locked addr kept", rd32, 32'hAAAA0000);
        do_wr(0, 1, 0, 64'h01000203);
        chk("R8 partial err", err32, 1);
        do_rd(1, 0);
        chk("R8 per-byte mask", rd32, 32'h01800203);
    endtask

    task automatic t_tor();
        do_wr(0, 0, 4, 64'h4444);
        do_wr(0, 1, 1, 64'h00008800);
        chk("R8 pre-write lock used", err32, 0);
        do_rd(1, 1);
        chk("R8 both bytes stored", rd32, 32'h00008800);
        do_wr(0, 0, 4, 64'h777);
        chk("R6 tor-locked addr err", err32, 1);
        do_rd(0, 4);
        chk("R6 tor-locked addr kept", rd32, 32'h4444);
        do_wr(0, 1, 1, 64'h11);
        chk("R6 tor-locked cfg err", err32, 1);
        do_rd(1, 1);
        chk("R6 tor-locked cfg kept", rd32, 32'h00008800);
    endtask

    task automatic t_rv64();
        do_wr(1, 1, 0, 64'h0888000000000000);
        chk("R2 rv64 pack no err", err64, 0);
        do_wr(1, 0, 5, 64'h55);
        chk("R6 rv64 entry5 locked", err64, 1);
        do_wr(1, 0, 7, 64'h99);
        chk("R6 highest entry free", err64, 0);
        do_rd(0, 7);
        chk("R6 highest addr stored", rd64, 64'h99);
        do_wr(1, 1, 0, 64'h0102030405060708);
        chk("R8 rv64 partial err", err64, 1);
        do_rd(1, 0);
        chk("R8 rv64 mask", rd64, 64'h0188000405060708);
        do_wr(1, 1, 1, 64'hFFFFFFFFFFFFFFFF);
        chk("R4 odd csr err", err64, 1);
        chk("R4 odd csr no change", cfg64, 64'h0188000405060708);
        do_rd(1, 1);
        chk("R3 rv64 missing entries zero", rd64, 0);
    endtask

    task automatic t_rereset();
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        chk("R1 reset clears lock", cfg32, 0);
        chk("R1 reset clears rv64", cfg64, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_pack();
        t_range();
        t_lock();
        t_tor();
        t_rv64();
        t_rereset();
        if (!done) begin
            done = 1'b1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        #200000;
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog got=hung exp=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule